// File: doc/BRIEF.md
# Thermostat Alert Decision Logic

This block turns a stream of temperature conversion results into a single alert output with programmable debounce. Each time a conversion completes, the new 12-bit reading is compared as a signed number against a high and a low limit. The alert only changes after a programmed number of back-to-back conversions have all met the current fault condition. This keeps a noisy reading from toggling the alert. The limit values and mode bits come from a register file outside the block, and bus framing is also handled outside.

The block has two thermostat modes.

- **Comparator mode** gives a hysteresis loop. The alert turns on at or above the high limit and turns off only below the low limit.
- **Interrupt mode** latches the alert until software clears it. A clear comes from a register read, from a successful alert-response reply, or from shutdown. After each clear the block re-arms on the opposite limit, so high-limit and low-limit events alternate.

A status bit records which limit raised the most recent alert. The pin polarity is selectable.

Top module: `thermo_alert`

## Requirements
- R1: The fault-queue code selects how many consecutive faulting conversions change the alert: code 00 needs 1, code 01 needs 2, code 10 needs 4 and code 11 needs 6.
- R2: In comparator mode (`int_mode_i`=0) with the alert inactive, a conversion whose temperature is greater than or equal to `thi_i` is a fault. When the queued count is reached, the alert becomes active in the cycle after the last such conversion-done pulse.
- R3: In comparator mode with the alert active, only a temperature strictly below `tlo_i` is a fault. A reading between the two limits neither clears the alert nor counts toward clearing it.
- R4: A conversion that does not meet the current fault condition returns the consecutive-fault count to zero.
- R5: Faults are evaluated only in a cycle where `conv_done_i` is 1. With no conversion, read, alert-acknowledge, shutdown or soft-reset event, the alert state does not change.
- R6: In interrupt mode (`int_mode_i`=1), while armed on the high limit, the alert becomes active after the queued count of readings at or above `thi_i`. Once active, it holds regardless of further conversions.
- R7: In interrupt mode an active alert is cleared, one cycle later, by `reg_read_i`, `ara_ack_i` or `shdn_i` being 1. Each such clear switches the arming to the other limit, so the next alert needs readings below `tlo_i`.
- R8: After a low-limit alert is cleared in interrupt mode, the block is armed on the high limit again.
- R9: `cause_o` becomes 1 when an alert is raised by the high limit and 0 when it is raised by the low limit. It keeps its value until the next alert is raised.
- R10: `alert_pin_o` equals the internal alert state when `pol_i`=1 and its inverse when `pol_i`=0. This is combinational on `pol_i`.
- R11: A `soft_rst_i` pulse makes the alert inactive, clears `cause_o`, clears the fault count and arms on the high limit, all in the following cycle.
- R12: Temperature and limits are compared as 12-bit two's-complement values. For example, a high limit of 0xE70 (-25 °C) is exceeded by a reading of 0x7FF.
- R13: After `rst_n` is asserted, the alert is inactive (pin high when `pol_i`=0), `cause_o` is 0 and the block is armed on the high limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | 12 | Latest conversion result, two's complement |
| thi_i | input | 12 | High limit, two's complement |
| tlo_i | input | 12 | Low limit, two's complement |
| fq_code_i | input | 2 | Fault-queue depth code |
| int_mode_i | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| pol_i | input | 1 | Alert pin polarity, 1 = active high |
| shdn_i | input | 1 | Shutdown level; clears a latched interrupt alert |
| conv_done_i | input | 1 | One-cycle pulse: `temp_i` holds a new result |
| reg_read_i | input | 1 | One-cycle pulse: a register was read |
| ara_ack_i | input | 1 | One-cycle pulse: alert-response reply completed |
| soft_rst_i | input | 1 | One-cycle synchronous soft reset |
| alert_pin_o | output | 1 | Alert pin after polarity |
| cause_o | output | 1 | 1 = high limit raised the alert, 0 = low limit |

## Verification
The bound checker verifies the following on every cycle:
- the alert moves only on conversion or clear events;
- a latched interrupt alert never drops without a clear;
- a read clears it within one cycle;
- a comparator-mode alert always reports the high limit;
- soft reset leaves the alert inactive.

Other behaviours need the bench's scenarios, which drive readings against a reference model:
- the exact queue depth for each code;
- the counter restarting after a non-faulting reading;
- hysteresis between the limits;
- alternation of high and low arming;
- signed comparison across the sign boundary.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  typedef enum logic [1:0] {
    FQ_ONE  = 2'b00,
    FQ_TWO  = 2'b01,
    FQ_FOUR = 2'b10,
    FQ_SIX  = 2'b11
  } fq_code_e;

  localparam int FQ_MAX_DEPTH = 6;

  // Number of consecutive faulting conversions needed per queue code (R1)
  function automatic logic [2:0] fq_depth(input logic [1:0] code);
    logic [2:0] d;
    unique case (fq_code_e'(code))
      FQ_ONE:  d = 3'd1;
      FQ_TWO:  d = 3'd2;
      FQ_FOUR: d = 3'd4;
      default: d = 3'd6;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/thermo_fault_cmp.sv
module thermo_fault_cmp #(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] thi_i,
  input  logic [TEMP_W-1:0] tlo_i,
  input  logic              sel_low_i,
  output logic              fault_o
);

  logic at_or_above_hi;
  logic below_lo;

  // Full-width two's-complement compare (R12)
  assign at_or_above_hi = $signed(temp_i) >= $signed(thi_i);
  assign below_lo       = $signed(temp_i) <  $signed(tlo_i);

  assign fault_o = sel_low_i ? below_lo : at_or_above_hi;

endmodule

// File: rtl/thermo_fault_cnt.sv
module thermo_fault_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             eval_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_en;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit_o   = eval_i & fault_i & (cnt_inc >= need_i);
  assign cnt_en  = clr_i | eval_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (eval_i) begin
      if (!fault_i || hit_o) cnt_d = '0;   // R4: a miss restarts the count
      else                   cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/thermo_alert_fsm.sv
module thermo_alert_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic int_mode_i,
  input  logic clr_evt_i,
  input  logic hit_i,
  output logic alert_o,
  output logic cause_o,
  output logic arm_low_o,
  output logic int_clr_o
);

  logic alert_q, alert_d;
  logic cause_q, cause_d;
  logic arm_q,   arm_d;

  assign int_clr_o = int_mode_i & alert_q & clr_evt_i;

  always_comb begin
    alert_d = alert_q;
    cause_d = cause_q;
    arm_d   = arm_q;
    if (soft_rst_i) begin
      alert_d = 1'b0;
      cause_d = 1'b0;
      arm_d   = 1'b0;
    end else if (int_mode_i) begin
      if (int_clr_o) begin
        alert_d = 1'b0;
        arm_d   = ~arm_q;
      end else if (hit_i) begin
        alert_d = 1'b1;
        cause_d = ~arm_q;
      end
    end else begin
      arm_d = 1'b0;
      if (hit_i) begin
        alert_d = ~alert_q;
        if (!alert_q) cause_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      cause_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      alert_q <= alert_d;
      cause_q <= cause_d;
      arm_q   <= arm_d;
    end
  end

  assign alert_o   = alert_q;
  assign cause_o   = cause_q;
  assign arm_low_o = arm_q;

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert #(
  parameter int TEMP_W = 12,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] thi_i,
  input  logic [TEMP_W-1:0] tlo_i,
  input  logic [1:0]        fq_code_i,
  input  logic              int_mode_i,
  input  logic              pol_i,
  input  logic              shdn_i,
  input  logic              conv_done_i,
  input  logic              reg_read_i,
  input  logic              ara_ack_i,
  input  logic              soft_rst_i,
  output logic              alert_pin_o,
  output logic              cause_o
);
  import thermo_pkg::*;

  logic             alert_q;
  logic             cause_q;
  logic             arm_low_q;
  logic             int_clr;
  logic             sel_low;
  logic             fault;
  logic             hit;
  logic             eval_en;
  logic             clr_evt;
  logic             cnt_clr;
  logic [CNT_W-1:0] need;

  assign need    = CNT_W'(fq_depth(fq_code_i));
  assign clr_evt = reg_read_i | ara_ack_i | shdn_i;
  assign sel_low = int_mode_i ? arm_low_q : alert_q;
  assign eval_en = conv_done_i & ~(int_mode_i & alert_q);
  assign cnt_clr = soft_rst_i | int_clr;

  thermo_fault_cmp #(.TEMP_W(TEMP_W)) cmp_i (
    .temp_i    (temp_i),
    .thi_i     (thi_i),
    .tlo_i     (tlo_i),
    .sel_low_i (sel_low),
    .fault_o   (fault)
  );

  thermo_fault_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .eval_i  (eval_en),
    .fault_i (fault),
    .need_i  (need),
    .hit_o   (hit)
  );

  thermo_alert_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .int_mode_i (int_mode_i),
    .clr_evt_i  (clr_evt),
    .hit_i      (hit),
    .alert_o    (alert_q),
    .cause_o    (cause_q),
    .arm_low_o  (arm_low_q),
    .int_clr_o  (int_clr)
  );

  assign alert_pin_o = pol_i ? alert_q : ~alert_q;
  assign cause_o     = cause_q;

endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk (
  input logic clk,
  input logic rst_n,
  input logic int_mode_i,
  input logic conv_done_i,
  input logic reg_read_i,
  input logic ara_ack_i,
  input logic shdn_i,
  input logic soft_rst_i,
  input logic alert_q,
  input logic cause_q
);

  p_quiet_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done_i && !reg_read_i && !ara_ack_i && !shdn_i && !soft_rst_i)
      |=> $stable(alert_q));

  p_rise_needs_conv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_q) |-> $past(conv_done_i));

  p_latched_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode_i && alert_q && !reg_read_i && !ara_ack_i && !shdn_i && !soft_rst_i)
      |=> alert_q);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode_i && alert_q && reg_read_i) |=> !alert_q);

  p_cmp_cause_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alert_q) && !$past(int_mode_i) && !$past(soft_rst_i)) |-> cause_q);

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!alert_q && !cause_q));

endmodule

bind thermo_alert thermo_alert_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_mode_i  (int_mode_i),
  .conv_done_i (conv_done_i),
  .reg_read_i  (reg_read_i),
  .ara_ack_i   (ara_ack_i),
  .shdn_i      (shdn_i),
  .soft_rst_i  (soft_rst_i),
  .alert_q     (alert_q),
  .cause_q     (cause_q)
);

// File: tb/thermo_alert_tb_top.sv
`timescale 1ns/1ps
module thermo_alert_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] temp, thi, tlo;
  logic [1:0]  fq;
  logic        intm, pol, shdn, conv, rd, ara, srst;
  logic        pin, cause;

  int checks = 0;
  int errors = 0;

  // reference state
  logic m_alert, m_cause, m_arm;
  int   m_cnt;

  always #2 clk = ~clk;

  thermo_alert dut_i (
    .clk(clk), .rst_n(rst_n), .temp_i(temp), .thi_i(thi), .tlo_i(tlo),
    .fq_code_i(fq), .int_mode_i(intm), .pol_i(pol), .shdn_i(shdn),
    .conv_done_i(conv), .reg_read_i(rd), .ara_ack_i(ara), .soft_rst_i(srst),
    .alert_pin_o(pin), .cause_o(cause)
  );

  function automatic int queue_len(input logic [1:0] c);
    case (c)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic exp_pin(input logic a, input logic p);
    return p ? a : ~a;
  endfunction

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, got, exp, $time);
    end
  endtask

  // expected next state from current inputs
  task automatic model_step();
    logic want_low, flt;
    if (srst) begin
      m_alert = 0; m_cause = 0; m_arm = 0; m_cnt = 0;
    end else if (intm && m_alert && (rd || ara || shdn)) begin
      m_alert = 0; m_arm = ~m_arm; m_cnt = 0;
    end else begin
      if (!intm) m_arm = 0;
      if (conv && !(intm && m_alert)) begin
        want_low = intm ? m_arm : m_alert;
        flt = want_low ? ($signed(temp) < $signed(tlo)) : ($signed(temp) >= $signed(thi));
        if (!flt) m_cnt = 0;
        else if (m_cnt + 1 >= queue_len(fq)) begin
          m_cnt = 0;
          if (intm) begin m_alert = 1; m_cause = ~want_low; end
          else begin
            if (!m_alert) m_cause = 1;
            m_alert = ~m_alert;
          end
        end else m_cnt = m_cnt + 1;
      end
    end
  endtask

  task automatic cyc(input string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    conv = 0; rd = 0; ara = 0; srst = 0;
    check(req, pin, exp_pin(m_alert, pol), "pin");
    check(req, cause, m_cause, "cause");
  endtask

  task automatic convert(input logic [11:0] t, input string req);
    temp = t; conv = 1; cyc(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; temp = 0; thi = 12'h500; tlo = 12'h4B0; fq = 0;
    intm = 0; pol = 0; shdn = 0; conv = 0; rd = 0; ara = 0; srst = 0;
    m_alert = 0; m_cause = 0; m_arm = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R13", pin, 1'b1, "reset pin");
    check("R13", cause, 1'b0, "reset cause");
    pol = 1; #1;
    check("R10", pin, 1'b0, "active-high idle");
    pol = 0;
    @(negedge clk);

    // R1/R2: depth 4 comparator assert
    fq = 2'b10;
    for (int i = 0; i < 3; i++) convert(12'h500, "R1");
    check("R1", pin, 1'b1, "still idle after 3");
    convert(12'h510, "R2");
    check("R2", pin, 1'b0, "asserted after 4");
    check("R9", cause, 1'b1, "high cause");
    pol = 1; #1; check("R10", pin, 1'b1, "active-high asserted"); pol = 0;

    // R3: hysteresis
    fq = 2'b00;
    convert(12'h4C0, "R3");
    check("R3", pin, 1'b0, "between limits keeps alert");
    convert(12'h4AF, "R3");
    check("R3", pin, 1'b1, "below low clears");

    // R4: depth 2, miss restarts
    fq = 2'b01;
    convert(12'h600, "R4"); convert(12'h100, "R4"); convert(12'h600, "R4");
    check("R4", pin, 1'b1, "no alert after reset count");
    // R5: no conv -> no change
    temp = 12'h700; cyc("R5"); cyc("R5");
    check("R5", pin, 1'b1, "idle without conv");
    convert(12'h600, "R4");
    check("R4", pin, 1'b0, "alert after two consecutive");

    // R11 soft reset
    srst = 1; cyc("R11");
    check("R11", pin, 1'b1, "soft reset clears");
    check("R11", cause, 1'b0, "soft reset cause");

    // R12 signed compare
    fq = 2'b00; thi = 12'hE70; tlo = 12'hC90;
    convert(12'h7FF, "R12");
    check("R12", pin, 1'b0, "0x7FF >= 0xE70 signed");
    convert(12'hC8F, "R12");
    check("R12", pin, 1'b1, "below negative low");
    thi = 12'h500; tlo = 12'h4B0;

    // R6..R9 interrupt alternation, depth 6
    intm = 1; fq = 2'b11;
    for (int i = 0; i < 5; i++) convert(12'h520, "R1");
    check("R1", pin, 1'b1, "five of six");
    convert(12'h520, "R6");
    check("R6", pin, 1'b0, "interrupt high asserted");
    check("R9", cause, 1'b1, "high cause");
    convert(12'h000, "R6");
    check("R6", pin, 1'b0, "latched despite low temp");
    rd = 1; cyc("R7");
    check("R7", pin, 1'b1, "read clears");
    fq = 2'b00;
    convert(12'h520, "R7");
    check("R7", pin, 1'b1, "high ignored when armed low");
    convert(12'h4A0, "R7");
    check("R7", pin, 1'b0, "low alert");
    check("R9", cause, 1'b0, "low cause");
    shdn = 1; cyc("R7"); shdn = 0;
    check("R7", pin, 1'b1, "shutdown clears");
    convert(12'h400, "R8");
    check("R8", pin, 1'b1, "low ignored when armed high");
    convert(12'h500, "R8");
    check("R8", pin, 1'b0, "rearmed on high");
    ara = 1; cyc("R7");
    check("R7", pin, 1'b1, "alert reply clears");

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if ($urandom % 300 == 0) intm = ~intm;
      if ($urandom % 250 == 0) fq = 2'($urandom);
      if ($urandom % 80 == 0)  pol = ~pol;
      thi  = 12'h500 + 12'($urandom % 16);
      tlo  = thi - 12'(1 + $urandom % 24);
      temp = tlo - 12'd8 + 12'($urandom % 48);
      conv = ($urandom % 3 == 0);
      rd   = ($urandom % 17 == 0);
      ara  = ($urandom % 23 == 0);
      shdn = ($urandom % 29 == 0);
      srst = ($urandom % 400 == 0);
      cyc("R5");
      shdn = 0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule